// File: doc/BRIEF.md
# Phase-Tag PI Loop Filter with Lock Detection

This block turns a stream of phase-detector tags into a control word for a DAC-steered oscillator. Each tag holds a raw phase value and a flag marking that the detector counter rolled over since the previous tag. The block rebuilds a continuous phase from these tags, takes the step between two consecutive phase values as the loop error, and feeds it to a proportional-integral controller. The controller output is offset by a fixed bias and held inside a safe window. When the output is held at an edge of that window, the integrator stops accumulating.

A lock detector watches the same error stream. It raises a flag once the error has stayed inside a tolerance band for a long unbroken run of samples, and drops the flag at the first sample outside that band. A synchronous start input returns the loop to its initial state. This lets the control code restart acquisition without a full reset.

Top module: `pi_lock_filter`

## Requirements
- R1: `tag_i` carries the wrap flag in bit TAG_W. Bits TAG_W-1..0 hold the raw phase, read as unsigned.
- R2: On a sample with the wrap flag set, the phase offset drops by 2^TAG_W when the new raw value is greater than the previous raw value. Otherwise it grows by 2^TAG_W. On a sample without the flag the offset is left alone.
- R3: The loop error is (raw + offset) minus the previous unwrapped phase. The new unwrapped phase and the new raw value are kept for the next sample. Both start at zero.
- R4: One cycle after an accepted sample, `dac_o` shows clamp(((I + e)*KI + e*KP) >>> SHIFT + BIAS). Here I is the integrator and e is the error. The shift is arithmetic, so it rounds toward minus infinity.
- R5: `dac_o` never leaves [Y_MIN, Y_MAX]. With the defaults these are 5 and 2^DAC_W-5.
- R6: The integrator takes the value I + e only when the unclamped output lies inside the window. On a sample that clamps, the integrator keeps its old value.
- R7: `locked_o` rises one cycle after the LD_SAMPLES-th consecutive sample whose error magnitude is at most LD_THRESH.
- R8: A sample whose error magnitude is above LD_THRESH clears the run counter, and `locked_o` is low in the next cycle.
- R9: `start_i` overrides a coincident sample. It clears the offset, the previous raw and unwrapped values, the integrator and the run counter. In the next cycle `dac_o` equals BIAS (clamped) and `locked_o` is 0.
- R10: In cycles without `sample_valid_i` or `start_i`, `dac_o`, `locked_o` and all loop state hold their values.
- R11: After reset, `dac_o` equals BIAS (clamped), `locked_o` is 0 and all loop state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous restart of the loop state |
| sample_valid_i | input | 1 | Marks the cycle that carries a tag |
| tag_i | input | TAG_W+1 | Wrap flag (MSB) and raw phase |
| dac_o | output | DAC_W | Clamped controller output |
| locked_o | output | 1 | Lock indication |

## Verification
The bench builds the block with TAG_W=8, KI=64, SHIFT=6 and LD_SAMPLES=20, and leaves KP, BIAS, DAC_W and LD_THRESH at their defaults. The 8-bit tags wrap every few samples, so both offset directions are exercised often. A KI of 64 makes the integrator reach the upper and lower clamps within a few hundred samples, so the anti-windup release can be observed. A run length of 20 lets the bench acquire lock, break it and acquire it again several times in a short run.

// File: rtl/pll_filt_pkg.sv
`timescale 1ns/1ps
package pll_filt_pkg;
  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_LO   = 2'd1,
    CLAMP_HI   = 2'd2
  } clamp_e;
endpackage

// File: rtl/pll_phase_unwrap.sv
`timescale 1ns/1ps
module pll_phase_unwrap #(
  parameter int TAG_W = 14,
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    valid_i,
  input  logic [TAG_W:0]          tag_i,
  output logic signed [ACC_W-1:0] err_o
);
  localparam logic signed [ACC_W-1:0] SPAN = ACC_W'(1) <<< TAG_W;

  logic [TAG_W-1:0]        raw_q;
  logic signed [ACC_W-1:0] off_q, off_d, ph_q, ph_d;
  logic [TAG_W-1:0]        raw_in;
  logic                    wrap_in;

  assign raw_in  = tag_i[TAG_W-1:0];
  assign wrap_in = tag_i[TAG_W];

  always_comb begin
    off_d = off_q;
    if (wrap_in) begin
      if (raw_in > raw_q) off_d = off_q - SPAN;
      else                off_d = off_q + SPAN;
    end
    ph_d  = $signed({{(ACC_W-TAG_W){1'b0}}, raw_in}) + off_d;
    err_o = ph_d - ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      off_q <= '0;
      ph_q  <= '0;
    end else if (start_i) begin
      raw_q <= '0;
      off_q <= '0;
      ph_q  <= '0;
    end else if (valid_i) begin
      raw_q <= raw_in;
      off_q <= off_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/pll_pi_ctrl.sv
`timescale 1ns/1ps
module pll_pi_ctrl
  import pll_filt_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int DAC_W = 16,
  parameter int KP    = 300,
  parameter int KI    = 1,
  parameter int SHIFT = 10,
  parameter int BIAS  = 32768,
  parameter int Y_MIN = 5,
  parameter int Y_MAX = (1 << DAC_W) - 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    valid_i,
  input  logic signed [ACC_W-1:0] err_i,
  output logic [DAC_W-1:0]        dac_o
);
  localparam int PROD_W = ACC_W + 20;
  localparam logic signed [PROD_W-1:0] KP_S   = PROD_W'(KP);
  localparam logic signed [PROD_W-1:0] KI_S   = PROD_W'(KI);
  localparam logic signed [PROD_W-1:0] BIAS_S = PROD_W'(BIAS);
  localparam logic signed [PROD_W-1:0] MIN_S  = PROD_W'(Y_MIN);
  localparam logic signed [PROD_W-1:0] MAX_S  = PROD_W'(Y_MAX);
  localparam logic [DAC_W-1:0] DAC_RST =
    (BIAS < Y_MIN) ? DAC_W'(Y_MIN) : (BIAS > Y_MAX) ? DAC_W'(Y_MAX) : DAC_W'(BIAS);

  logic signed [ACC_W-1:0]  integ_q, integ_new;
  logic signed [PROD_W-1:0] i_ext, e_ext, sum, y_raw;
  clamp_e                   clamp_st;
  logic [DAC_W-1:0]         y_sat;

  always_comb begin
    integ_new = integ_q + err_i;
    i_ext     = {{(PROD_W-ACC_W){integ_new[ACC_W-1]}}, integ_new};
    e_ext     = {{(PROD_W-ACC_W){err_i[ACC_W-1]}}, err_i};
    sum       = i_ext * KI_S + e_ext * KP_S;
    y_raw     = (sum >>> SHIFT) + BIAS_S;
    if (y_raw < MIN_S) begin
      clamp_st = CLAMP_LO;
      y_sat    = DAC_W'(Y_MIN);
    end else if (y_raw > MAX_S) begin
      clamp_st = CLAMP_HI;
      y_sat    = DAC_W'(Y_MAX);
    end else begin
      clamp_st = CLAMP_NONE;
      y_sat    = y_raw[DAC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      dac_o   <= DAC_RST;
    end else if (start_i) begin
      integ_q <= '0;
      dac_o   <= DAC_RST;
    end else if (valid_i) begin
      dac_o <= y_sat;
      if (clamp_st == CLAMP_NONE) integ_q <= integ_new;  // anti-windup
    end
  end
endmodule

// File: rtl/pll_lock_det.sv
`timescale 1ns/1ps
module pll_lock_det #(
  parameter int ACC_W      = 32,
  parameter int LD_THRESH  = 250,
  parameter int LD_SAMPLES = 10000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    valid_i,
  input  logic signed [ACC_W-1:0] err_i,
  output logic                    locked_o
);
  localparam int CNT_W = $clog2(LD_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LD_SAMPLES);
  localparam logic signed [ACC_W-1:0] TH_P = ACC_W'(LD_THRESH);
  localparam logic signed [ACC_W-1:0] TH_N = -ACC_W'(LD_THRESH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_band;

  assign in_band = (err_i <= TH_P) && (err_i >= TH_N);

  always_comb begin
    cnt_d = cnt_q;
    if (!in_band)            cnt_d = '0;
    else if (cnt_q < CNT_TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
    end else if (valid_i) begin
      cnt_q    <= cnt_d;
      locked_o <= (cnt_d == CNT_TOP);
    end
  end
endmodule

// File: rtl/pi_lock_filter.sv
`timescale 1ns/1ps
module pi_lock_filter #(
  parameter int TAG_W      = 14,
  parameter int DAC_W      = 16,
  parameter int ACC_W      = 32,
  parameter int KP         = 300,
  parameter int KI         = 1,
  parameter int SHIFT      = 10,
  parameter int BIAS       = 32768,
  parameter int Y_MIN      = 5,
  parameter int Y_MAX      = (1 << DAC_W) - 5,
  parameter int LD_THRESH  = 250,
  parameter int LD_SAMPLES = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sample_valid_i,
  input  logic [TAG_W:0]   tag_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             locked_o
);
  logic signed [ACC_W-1:0] err_w;

  pll_phase_unwrap #(.TAG_W(TAG_W), .ACC_W(ACC_W)) u_unwrap (
    .clk_i, .rst_ni, .start_i, .valid_i(sample_valid_i), .tag_i, .err_o(err_w)
  );

  pll_pi_ctrl #(
    .ACC_W(ACC_W), .DAC_W(DAC_W), .KP(KP), .KI(KI), .SHIFT(SHIFT),
    .BIAS(BIAS), .Y_MIN(Y_MIN), .Y_MAX(Y_MAX)
  ) u_pi (
    .clk_i, .rst_ni, .start_i, .valid_i(sample_valid_i), .err_i(err_w), .dac_o
  );

  pll_lock_det #(.ACC_W(ACC_W), .LD_THRESH(LD_THRESH), .LD_SAMPLES(LD_SAMPLES)) u_lock (
    .clk_i, .rst_ni, .start_i, .valid_i(sample_valid_i), .err_i(err_w), .locked_o
  );
endmodule

// File: rtl/pi_lock_filter_chk.sv
`timescale 1ns/1ps
module pi_lock_filter_chk #(
  parameter int DAC_W     = 16,
  parameter int ACC_W     = 32,
  parameter int BIAS      = 32768,
  parameter int Y_MIN     = 5,
  parameter int Y_MAX     = (1 << DAC_W) - 5,
  parameter int LD_THRESH = 250
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    sample_valid_i,
  input logic signed [ACC_W-1:0] err_w,
  input logic [DAC_W-1:0]        dac_o,
  input logic                    locked_o
);
  localparam logic [DAC_W-1:0] DAC_RST =
    (BIAS < Y_MIN) ? DAC_W'(Y_MIN) : (BIAS > Y_MAX) ? DAC_W'(Y_MAX) : DAC_W'(BIAS);
  localparam logic signed [ACC_W-1:0] TH_P = ACC_W'(LD_THRESH);
  localparam logic signed [ACC_W-1:0] TH_N = -ACC_W'(LD_THRESH);

  assert_dac_in_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_o >= DAC_W'(Y_MIN)) && (dac_o <= DAC_W'(Y_MAX)));

  assert_start_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (dac_o == DAC_RST) && !locked_o);

  assert_idle_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !sample_valid_i) |=> $stable(dac_o) && $stable(locked_o));

  assert_big_err_unlocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !start_i && ((err_w > TH_P) || (err_w < TH_N))) |=> !locked_o);

  assert_lock_needs_sample_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(sample_valid_i) && !$past(start_i));
endmodule

bind pi_lock_filter pi_lock_filter_chk #(
  .DAC_W(DAC_W), .ACC_W(ACC_W), .BIAS(BIAS), .Y_MIN(Y_MIN), .Y_MAX(Y_MAX),
  .LD_THRESH(LD_THRESH)
) u_chk (
  .clk_i, .rst_ni, .start_i, .sample_valid_i, .err_w, .dac_o, .locked_o
);

// File: tb/pi_lock_filter_tb_top.sv
`timescale 1ns/1ps
module pi_lock_filter_tb_top;
  localparam int TAG_W = 8, DAC_W = 16, KP = 300, KI = 64, SHIFT = 6;
  localparam int BIAS = 32768, Y_MIN = 5, Y_MAX = (1 << DAC_W) - 5;
  localparam int LD_THRESH = 250, LD_SAMPLES = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, vld = 1'b0;
  logic [TAG_W:0] tag = '0;
  logic [DAC_W-1:0] dac;
  logic locked;
  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R11";
  bit seen_hi = 0, seen_lo = 0;

  always #2.5 clk = ~clk;

  pi_lock_filter #(
    .TAG_W(TAG_W), .DAC_W(DAC_W), .ACC_W(32), .KP(KP), .KI(KI), .SHIFT(SHIFT),
    .BIAS(BIAS), .Y_MIN(Y_MIN), .Y_MAX(Y_MAX), .LD_THRESH(LD_THRESH), .LD_SAMPLES(LD_SAMPLES)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sample_valid_i(vld), .tag_i(tag),
    .dac_o(dac), .locked_o(locked)
  );

  // behavioural reference
  longint m_raw, m_off, m_ph, m_int, m_dac;
  int m_cnt;
  bit m_lk;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || start) begin
      m_raw = 0; m_off = 0; m_ph = 0; m_int = 0; m_cnt = 0; m_lk = 0; m_dac = BIAS;
    end else if (vld) begin
      longint raw, ph, e, inew, y;
      raw = longint'(tag[TAG_W-1:0]);
      if (tag[TAG_W]) m_off = (raw > m_raw) ? m_off - (1 << TAG_W) : m_off + (1 << TAG_W);
      ph = raw + m_off;
      e = ph - m_ph;
      m_ph = ph; m_raw = raw;
      inew = m_int + e;
      y = ((inew * KI + e * KP) >>> SHIFT) + BIAS;
      if (y < Y_MIN) m_dac = Y_MIN;
      else if (y > Y_MAX) m_dac = Y_MAX;
      else begin m_dac = y; m_int = inew; end
      if (e <= LD_THRESH && e >= -LD_THRESH) begin
        if (m_cnt < LD_SAMPLES) m_cnt++;
        m_lk = (m_cnt == LD_SAMPLES);
      end else begin
        m_cnt = 0; m_lk = 0;
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // per-cycle compare, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(dac == DAC_W'(m_dac), {cur_req, " dac"}, longint'(dac), m_dac);
      chk(locked == m_lk, {cur_req, " locked"}, longint'(locked), longint'(m_lk));
      if (dac == DAC_W'(Y_MAX)) seen_hi = 1;
      if (dac == DAC_W'(Y_MIN)) seen_lo = 1;
    end
    if (cycles > 100000) begin
      chk(0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  task automatic put(bit w, int raw);
    @(negedge clk);
    vld = 1; start = 0; tag = {w, 8'(raw)};
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); vld = 0; start = 0; end
  endtask
  task automatic restart();
    @(negedge clk); vld = 0; start = 1;
    @(negedge clk); start = 0;
  endtask

  initial begin
    int r;
    logic [DAC_W-1:0] held;
    repeat (3) @(negedge clk);
    chk(dac == DAC_W'(BIAS) && !locked, "R11 reset state", longint'(dac), BIAS);
    @(negedge clk); rst_n = 1;
    idle(2);
    chk(dac == DAC_W'(BIAS) && !locked, "R11 after release", longint'(dac), BIAS);

    // R7: lock after LD_SAMPLES small-error samples
    cur_req = "R7";
    put(0, 50);
    for (int i = 1; i < LD_SAMPLES - 1; i++) put(0, 50);
    idle(1);
    chk(locked == 0, "R7 before run end", longint'(locked), 0);
    put(0, 50);
    idle(1);
    chk(locked == 1, "R7 lock at run end", longint'(locked), 1);

    // R10: idle holds
    cur_req = "R10";
    held = dac;
    idle(5);
    chk(dac == held && locked, "R10 idle hold", longint'(dac), longint'(held));

    // R8: large error drops lock
    cur_req = "R8";
    put(0, 0);
    put(0, 252);
    idle(1);
    chk(locked == 0, "R8 unlock on big error", longint'(locked), 0);

    // R1 R2 R3: forward and backward wraps
    cur_req = "R2";
    r = 0;
    for (int i = 0; i < 60; i++) begin
      int nr;
      nr = r + 40;
      put(nr >= 256, nr % 256);
      r = nr % 256;
    end
    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      int nr;
      nr = r - 20;
      put(nr < 0, (nr + 256) % 256);
      r = (nr + 256) % 256;
    end
    cur_req = "R1";
    put(1, r);
    put(1, r);

    // R5 R6: drive into upper clamp, then lower, then release
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      int nr;
      nr = r + 200;
      put(nr >= 256, nr % 256);
      r = nr % 256;
    end
    chk(seen_hi, "R5 upper clamp reached", longint'(seen_hi), 1);
    for (int i = 0; i < 800; i++) begin
      int nr;
      nr = r - 200;
      put(nr < 0, (nr + 256) % 256);
      r = (nr + 256) % 256;
    end
    chk(seen_lo, "R5 lower clamp reached", longint'(seen_lo), 1);
    for (int i = 0; i < 300; i++) begin
      int nr;
      nr = r + 30;
      put(nr >= 256, nr % 256);
      r = nr % 256;
    end
    cur_req = "R5";

    // R9: start overrides coincident sample
    cur_req = "R9";
    @(negedge clk); vld = 1; start = 1; tag = {1'b1, 8'd77};
    @(negedge clk); vld = 0; start = 0;
    chk(dac == DAC_W'(BIAS) && !locked, "R9 start clears", longint'(dac), BIAS);
    r = 0;

    // R4: mixed stimulus with gaps
    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      int step;
      step = $urandom_range(0, 60) - 30;
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
      else begin
        int nr;
        nr = r + step;
        put(nr >= 256 || nr < 0, (nr + 256) % 256);
        r = (nr + 256) % 256;
      end
      if (i == 1500) restart();
      if (i == 1500) r = 0;
    end
    idle(3);
    finish_run();
  end
endmodule